// File: doc/BRIEF.md
# Keyboard Serial Receive Controller

This block takes in frames from a two-wire keyboard link, where the clock line and the data line are both open-drain. The keyboard drives the clock. The block samples the data line once per falling clock edge. It gathers the eight data bits, which arrive least significant bit first. It then checks the odd parity bit and records the stop bit. The finished byte goes into a buffer register, and a buffer-full flag is raised.

Once a byte is buffered, the block pulls the clock line low. The keyboard cannot send another frame while the line is held. Software reads the byte and the two status flags, then clears the buffer-full flag. Clearing the flag lets the clock line go and makes the receiver ready for the next frame.

Software enables reception with a level input. Reception starts only when both synchronized line levels read high. Both synchronized levels are available on output ports, so software can check the link before it enables the block. An interrupt output can be enabled; it follows the buffer-full flag.

Top module: `kbd_rx_ctrl`

## Requirements
- R1: A frame is one start bit at 0, then 8 data bits with the least significant bit first, then a parity bit, then a stop bit. Each bit is captured on a falling edge of the synchronized clock line. The 8 data bits appear on `rxByte`, with the first data bit in bit 0.
- R2: Raising `rxEnable` makes `rxActive` go high only while both `lineClk` and `lineData` read 1. Otherwise the block stays idle with `rxActive` at 0.
- R3: On the falling edge that captures the stop bit, `bufFull` and `kbClkPullLow` are set in the same cycle. `kbClkPullLow` stays at 1 only while `bufFull` is 1.
- R4: `irq` is 1 exactly while both `bufFull` and `irqEnable` are 1, so it rises in the same cycle as `bufFull`.
- R5: A `fullClear` pulse while the buffer is full clears `bufFull` and releases the clock line on the next cycle, with `rxActive` still 1. A `fullClear` pulse while the buffer is empty changes no output.
- R6: `parityErr` is set for a frame when the 8 data bits plus the parity bit hold an even number of ones. It is cleared when that count is odd.
- R7: `stopBit` holds the value of the stop bit sampled in the last completed frame.
- R8: A start bit sampled as 1 is discarded. The block keeps waiting for a start bit at 0, and the buffer and its flags stay unchanged.
- R9: If a frame has started and no falling clock edge arrives within `TIMEOUT_CYCLES` system cycles, the partial frame is dropped. The next full frame is then received correctly.
- R10: Lowering `rxEnable` sets `rxActive` and `kbClkPullLow` to 0 on the next cycle and drops any partial frame.
- R11: While `bufFull` is 1 and no clear is requested, `rxByte` and `bufFull` hold their values whatever the lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kbClkIn | input | 1 | Level sensed on the keyboard clock line |
| kbDataIn | input | 1 | Level sensed on the keyboard data line |
| kbClkPullLow | output | 1 | 1 pulls the open-drain clock line low |
| rxEnable | input | 1 | Software receive enable (level) |
| irqEnable | input | 1 | Software interrupt enable (level) |
| fullClear | input | 1 | One-cycle pulse that acknowledges the buffered byte |
| lineClk | output | 1 | Synchronized clock line level |
| lineData | output | 1 | Synchronized data line level |
| rxActive | output | 1 | 1 while reception is enabled (waiting, receiving or holding) |
| rxByte | output | 8 | Last received data byte |
| bufFull | output | 1 | A byte is buffered and has not been acknowledged |
| parityErr | output | 1 | Parity of the last frame was not odd |
| stopBit | output | 1 | Sampled stop-bit value of the last frame |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that `fullClear` is a single-cycle pulse. They also assume that the line inputs change slowly compared with the system clock, so the synchronizers never miss a keyboard clock phase. The stimulus keeps each keyboard clock half-period at 20 system cycles, well below the timeout window the bench configures. It changes every input only on the falling edge of the system clock. It models the open-drain clock line as the AND of the keyboard's drive and the block's release.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_START,
    ST_RECV,
    ST_HOLD
  } rx_state_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic frameStart;  // clear bit counter at a start bit
    logic bitSample;   // shift one data/parity bit in
    logic frameDone;   // stop bit: load buffer and flags
    logic timerRun;    // inter-edge timeout counter enabled
    logic flagClear;   // acknowledge: clear buffer-full
  } rx_strobe_t;

endpackage

// File: rtl/kbd_rx_datapath.sv
module kbd_rx_datapath
  import kbd_rx_pkg::*;
#(
  parameter int DATA_BITS      = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 kbClkIn,
  input  logic                 kbDataIn,
  input  rx_strobe_t           strobe,
  output logic                 syncClk,
  output logic                 syncData,
  output logic                 fallEdge,
  output logic                 lastBit,
  output logic                 timeout,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 bufFull,
  output logic                 parityErr,
  output logic                 stopBit
);

  // samples before the stop bit: data bits plus parity
  localparam int PRE_STOP = DATA_BITS + 1;
  localparam int CNT_W    = $clog2(PRE_STOP + 1);
  localparam int TMR_W    = $clog2(TIMEOUT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] clkPipe;
  logic [SYNC_STAGES-1:0] dataPipe;
  logic                   prevClk;
  logic [CNT_W-1:0]       bitCnt;
  logic [DATA_BITS:0]     shiftReg;
  logic [TMR_W-1:0]       idleTimer;

  // Synchronizers; reset to the idle (high) line level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clkPipe  <= '1;
          dataPipe <= '1;
        end else begin
          clkPipe  <= kbClkIn;
          dataPipe <= kbDataIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clkPipe  <= '1;
          dataPipe <= '1;
        end else begin
          clkPipe  <= {clkPipe[SYNC_STAGES-2:0], kbClkIn};
          dataPipe <= {dataPipe[SYNC_STAGES-2:0], kbDataIn};
        end
      end
    end
  endgenerate

  assign syncClk  = clkPipe[SYNC_STAGES-1];
  assign syncData = dataPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevClk <= 1'b1;
    else        prevClk <= syncClk;
  end

  assign fallEdge = prevClk & ~syncClk;

  // Bit counter and serial shift register (LSB arrives first)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (strobe.frameStart) begin
      bitCnt   <= '0;
    end else if (strobe.bitSample) begin
      bitCnt   <= bitCnt + CNT_W'(1);
      shiftReg <= {syncData, shiftReg[DATA_BITS:1]};
    end
  end

  assign lastBit = (bitCnt == CNT_W'(PRE_STOP));

  // Inter-edge watchdog within a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idleTimer <= '0;
    else if (!strobe.timerRun || fallEdge) idleTimer <= '0;
    else                                 idleTimer <= idleTimer + TMR_W'(1);
  end

  assign timeout = (idleTimer == TMR_W'(TIMEOUT_CYCLES - 1));

  // Receive buffer and status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxByte    <= '0;
      bufFull   <= 1'b0;
      parityErr <= 1'b0;
      stopBit   <= 1'b0;
    end else if (strobe.frameDone) begin
      rxByte    <= shiftReg[DATA_BITS-1:0];
      parityErr <= ~(^shiftReg);
      stopBit   <= syncData;
      bufFull   <= 1'b1;
    end else if (strobe.flagClear) begin
      bufFull   <= 1'b0;
    end
  end

endmodule

// File: rtl/kbd_rx_control.sv
module kbd_rx_control
  import kbd_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxEnable,
  input  logic       fullClear,
  input  logic       syncClk,
  input  logic       syncData,
  input  logic       fallEdge,
  input  logic       lastBit,
  input  logic       timeout,
  input  logic       bufFull,
  output rx_strobe_t strobe,
  output logic       rxActive,
  output logic       clkPullLow
);

  rx_state_e state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    strobe.flagClear = fullClear;
    if (!rxEnable) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (syncClk && syncData)
            stateNext = bufFull ? ST_HOLD : ST_WAIT_START;
        end
        ST_WAIT_START: begin
          if (fallEdge && !syncData) begin
            strobe.frameStart = 1'b1;
            stateNext         = ST_RECV;
          end
        end
        ST_RECV: begin
          strobe.timerRun = 1'b1;
          if (fallEdge) begin
            if (lastBit) begin
              strobe.frameDone = 1'b1;
              strobe.flagClear = 1'b0;
              stateNext        = ST_HOLD;
            end else begin
              strobe.bitSample = 1'b1;
            end
          end else if (timeout) begin
            stateNext = ST_WAIT_START;
          end
        end
        ST_HOLD: begin
          if (fullClear) stateNext = ST_WAIT_START;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign rxActive   = (state != ST_IDLE);
  assign clkPullLow = (state == ST_HOLD);

endmodule

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl
  import kbd_rx_pkg::*;
#(
  parameter int DATA_BITS      = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 kbClkIn,
  input  logic                 kbDataIn,
  output logic                 kbClkPullLow,
  input  logic                 rxEnable,
  input  logic                 irqEnable,
  input  logic                 fullClear,
  output logic                 lineClk,
  output logic                 lineData,
  output logic                 rxActive,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 bufFull,
  output logic                 parityErr,
  output logic                 stopBit,
  output logic                 irq
);

  rx_strobe_t strobe;
  logic       fallEdge;
  logic       lastBit;
  logic       timeout;

  kbd_rx_datapath #(
    .DATA_BITS     (DATA_BITS),
    .SYNC_STAGES   (SYNC_STAGES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .kbClkIn  (kbClkIn),
    .kbDataIn (kbDataIn),
    .strobe   (strobe),
    .syncClk  (lineClk),
    .syncData (lineData),
    .fallEdge (fallEdge),
    .lastBit  (lastBit),
    .timeout  (timeout),
    .rxByte   (rxByte),
    .bufFull  (bufFull),
    .parityErr(parityErr),
    .stopBit  (stopBit)
  );

  kbd_rx_control u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxEnable  (rxEnable),
    .fullClear (fullClear),
    .syncClk   (lineClk),
    .syncData  (lineData),
    .fallEdge  (fallEdge),
    .lastBit   (lastBit),
    .timeout   (timeout),
    .bufFull   (bufFull),
    .strobe    (strobe),
    .rxActive  (rxActive),
    .clkPullLow(kbClkPullLow)
  );

  assign irq = bufFull & irqEnable;

endmodule

// File: rtl/kbd_rx_checker.sv
module kbd_rx_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 kbClkPullLow,
  input logic                 rxEnable,
  input logic                 irqEnable,
  input logic                 fullClear,
  input logic                 lineClk,
  input logic                 lineData,
  input logic                 rxActive,
  input logic [DATA_BITS-1:0] rxByte,
  input logic                 bufFull,
  input logic                 irq
);

  // R2: enabled state is entered only from high line levels
  a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxActive) |-> $past(lineClk && lineData));

  // R3: new byte pulls the clock low at once
  a_r3_full_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bufFull) && rxEnable |-> kbClkPullLow);

  // R3: clock held low only while a byte waits
  a_r3_hold_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    kbClkPullLow |-> bufFull);

  // R4: interrupt rises together with the flag
  a_r4_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bufFull) && irqEnable |-> irq);

  // R5: acknowledge releases the line next cycle
  a_r5_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    fullClear && bufFull |=> !bufFull && !kbClkPullLow);

  // R10: disable drops back to idle
  a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> !rxActive && !kbClkPullLow);

  // R11: buffered byte is not overwritten
  a_r11_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    bufFull && !fullClear |=> bufFull && $stable(rxByte));

endmodule

bind kbd_rx_ctrl kbd_rx_checker #(.DATA_BITS(DATA_BITS)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .kbClkPullLow(kbClkPullLow),
  .rxEnable    (rxEnable),
  .irqEnable   (irqEnable),
  .fullClear   (fullClear),
  .lineClk     (lineClk),
  .lineData    (lineData),
  .rxActive    (rxActive),
  .rxByte      (rxByte),
  .bufFull     (bufFull),
  .irq         (irq)
);

// File: tb/kbd_rx_ctrl_bench.sv
module kbd_rx_ctrl_bench;

  localparam int HALF    = 20;
  localparam int TIMEOUT = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbdClk = 1'b1;
  logic       kbdData = 1'b1;
  logic       rxEnable = 1'b0;
  logic       irqEnable = 1'b0;
  logic       fullClear = 1'b0;
  logic       kbClkPullLow, lineClk, lineData, rxActive;
  logic [7:0] rxByte;
  logic       bufFull, parityErr, stopBit, irq;
  logic       kbClkLine;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // open-drain clock: low if either side pulls
  assign kbClkLine = kbdClk & ~kbClkPullLow;

  kbd_rx_ctrl #(.TIMEOUT_CYCLES(TIMEOUT)) u_kbd_rx_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .kbClkIn     (kbClkLine),
    .kbDataIn    (kbdData),
    .kbClkPullLow(kbClkPullLow),
    .rxEnable    (rxEnable),
    .irqEnable   (irqEnable),
    .fullClear   (fullClear),
    .lineClk     (lineClk),
    .lineData    (lineData),
    .rxActive    (rxActive),
    .rxByte      (rxByte),
    .bufFull     (bufFull),
    .parityErr   (parityErr),
    .stopBit     (stopBit),
    .irq         (irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends the first nBits of a frame; parity computed as odd unless flipped
  task automatic sendFrame(input logic [7:0] d, input bit badPar,
                           input bit stopVal, input bit startVal, input int nBits);
    logic [10:0] bits;
    bits = {stopVal, (~^d) ^ badPar, d, startVal};
    for (int i = 0; i < nBits; i++) begin
      kbdData = bits[i];
      waitCycles(HALF);
      kbdClk = 1'b0;
      waitCycles(HALF);
      kbdClk = 1'b1;
      waitCycles(1);
    end
    waitCycles(HALF);
    kbdData = 1'b1;
    waitCycles(4);
  endtask

  task automatic pulseClear();
    fullClear = 1'b1;
    waitCycles(1);
    fullClear = 1'b0;
    waitCycles(4);
  endtask

  task automatic tReset();
    check("R3", "reset bufFull", bufFull, 0);
    check("R3", "reset pull low", kbClkPullLow, 0);
    check("R4", "reset irq", irq, 0);
    check("R2", "reset rxActive", rxActive, 0);
  endtask

  task automatic tEnableGate();
    kbdData = 1'b0;
    waitCycles(4);
    rxEnable = 1'b1;
    waitCycles(10);
    check("R2", "enable blocked by low data", rxActive, 0);
    kbdData = 1'b1;
    waitCycles(6);
    check("R2", "enable with lines high", rxActive, 1);
  endtask

  task automatic tBasicFrame();
    sendFrame(8'hA5, 0, 1, 0, 11);
    check("R1", "byte A5", rxByte, 8'hA5);
    check("R3", "bufFull set", bufFull, 1);
    check("R3", "clock pulled low", kbClkPullLow, 1);
    check("R6", "parity ok", parityErr, 0);
    check("R7", "stop bit 1", stopBit, 1);
    check("R4", "irq off when disabled", irq, 0);
  endtask

  task automatic tHoldStable();
    kbdData = 1'b0;
    kbdClk  = 1'b0;
    waitCycles(10);
    kbdClk  = 1'b1;
    kbdData = 1'b1;
    waitCycles(10);
    check("R11", "byte held", rxByte, 8'hA5);
    check("R11", "still full", bufFull, 1);
    check("R3", "line reads low", lineClk, 0);
  endtask

  task automatic tClear();
    pulseClear();
    check("R5", "bufFull cleared", bufFull, 0);
    check("R5", "clock released", kbClkPullLow, 0);
    check("R5", "still active", rxActive, 1);
    check("R5", "line back high", lineClk, 1);
  endtask

  task automatic tIgnoredClear();
    pulseClear();
    check("R5", "idle clear keeps byte", rxByte, 8'hA5);
    check("R5", "idle clear keeps empty", bufFull, 0);
    check("R5", "idle clear keeps active", rxActive, 1);
    check("R5", "idle clear no pull", kbClkPullLow, 0);
  endtask

  task automatic tIrq();
    irqEnable = 1'b1;
    waitCycles(2);
    check("R4", "irq idle low", irq, 0);
    sendFrame(8'h3C, 0, 1, 0, 11);
    check("R1", "byte 3C", rxByte, 8'h3C);
    check("R4", "irq raised", irq, 1);
    pulseClear();
    check("R4", "irq dropped", irq, 0);
    irqEnable = 1'b0;
  endtask

  task automatic tParity();
    sendFrame(8'h17, 1, 1, 0, 11);
    check("R1", "byte 17", rxByte, 8'h17);
    check("R6", "parity error", parityErr, 1);
    pulseClear();
    sendFrame(8'h00, 0, 1, 0, 11);
    check("R6", "parity ok zero byte", parityErr, 0);
    pulseClear();
  endtask

  task automatic tStop();
    sendFrame(8'hC3, 0, 0, 0, 11);
    check("R7", "stop bit 0 recorded", stopBit, 0);
    check("R3", "full after bad stop", bufFull, 1);
    pulseClear();
  endtask

  task automatic tGlitch();
    sendFrame(8'h00, 0, 1, 1, 1);
    check("R8", "glitch no full", bufFull, 0);
    check("R8", "glitch byte kept", rxByte, 8'hC3);
    sendFrame(8'h5A, 0, 1, 0, 11);
    check("R8", "frame after glitch", rxByte, 8'h5A);
    pulseClear();
  endtask

  task automatic tTimeout();
    sendFrame(8'hFF, 0, 1, 0, 5);
    waitCycles(TIMEOUT + 50);
    check("R9", "no full after abort", bufFull, 0);
    sendFrame(8'h81, 0, 1, 0, 11);
    check("R9", "frame after timeout", rxByte, 8'h81);
    check("R9", "full after timeout", bufFull, 1);
    pulseClear();
  endtask

  task automatic tDisable();
    sendFrame(8'hE7, 0, 1, 0, 6);
    rxEnable = 1'b0;
    waitCycles(2);
    check("R10", "disabled inactive", rxActive, 0);
    check("R10", "disabled no pull", kbClkPullLow, 0);
    check("R10", "partial dropped", bufFull, 0);
    rxEnable = 1'b1;
    waitCycles(6);
    sendFrame(8'h42, 0, 1, 0, 11);
    check("R10", "frame after re-enable", rxByte, 8'h42);
    pulseClear();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    waitCycles(3);
    tReset();
    rst_n = 1'b1;
    waitCycles(3);
    tEnableGate();
    tBasicFrame();
    tHoldStable();
    tClear();
    tIgnoredClear();
    tIrq();
    tParity();
    tStop();
    tGlitch();
    tTimeout();
    tDisable();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule